// File: doc/BRIEF.md
# PWM Event-Trigger Interrupt Generator

This block sits beside a PWM time base and turns its event pulses into one interrupt request. Each cycle the time base reports single-cycle strobes for counter-at-zero, counter-at-period, compare-A match and compare-B match, plus the current count direction. A 3-bit source code picks one of these events. For the compare events the code also names the count direction in which the match counts. Selected events are counted. When the count reaches a programmed divider of one, two or three, a sticky interrupt flag is set and the counter restarts.

The flag stays high until software pulses the clear input. Events that arrive while the flag is high are still counted, but they cannot raise a second request. The running event count is brought out so software can see how far the divider has progressed.

Top module: `pwm_evt_irq`

## Requirements
- R1: After reset, irq_o is 0 and evt_cnt_o is 0.
- R2: Source code 3'b001 selects the zero strobe and 3'b010 selects the period strobe.
- R3: Code 3'b100 selects a compare-A strobe while dir_up_i=1, and 3'b101 selects it while dir_up_i=0. A compare-A strobe in the other direction is not an event.
- R4: Code 3'b110 selects a compare-B strobe while dir_up_i=1, and 3'b111 selects it while dir_up_i=0. A compare-B strobe in the other direction is not an event.
- R5: Codes 3'b000 and 3'b011 never produce an event: evt_cnt_o and irq_o do not change because of any strobe.
- R6: While en_i=0, strobes are ignored: no interrupt is raised and evt_cnt_o holds its value.
- R7: Divider code div_i 2'b01, 2'b10 or 2'b11 sets irq_o on the 1st, 2nd or 3rd selected event. On that same clock edge evt_cnt_o returns to 0. Before that edge, evt_cnt_o shows the number of events counted since the last firing. Code 2'b00 disables counting, and evt_cnt_o reads 0.
- R8: Outputs change on the clock edge that samples the strobe. Once set, irq_o stays 1 until clr_i is high at an edge. At that edge it falls, unless a new firing occurs in the same cycle.
- R9: While irq_o=1, selected events increment evt_cnt_o, saturating at the divider value, and cause no new firing. After a clear, the next event fires if the count already equals the divider.
- R10: If clr_i and a firing event fall in the same cycle, irq_o remains 1 and evt_cnt_o becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zero_i | input | 1 | Counter-at-zero strobe |
| period_i | input | 1 | Counter-at-period strobe |
| cmpa_i | input | 1 | Compare-A match strobe |
| cmpb_i | input | 1 | Compare-B match strobe |
| dir_up_i | input | 1 | 1 while the time base counts up |
| src_sel_i | input | 3 | Event source code |
| en_i | input | 1 | Interrupt generation enable |
| div_i | input | PRD_W | Events per interrupt (0 disables) |
| clr_i | input | 1 | Clear strobe for the interrupt flag |
| irq_o | output | 1 | Sticky interrupt flag |
| evt_cnt_o | output | PRD_W | Events counted toward the next firing |

## Verification
A faulty source decode appears as an event count that advances, or fails to advance, on the edge right after a strobe. It therefore shows on evt_cnt_o within one cycle, even when no interrupt follows. A wrong divider compare or a missed counter restart shows as irq_o rising one or two events early or late, and as a nonzero count where 0 is expected. A wrong flag hold or clear priority shows on irq_o on the cycle after the clear. The bench compares both outputs against a reference model after every clock edge, so each of these faults is reported on the cycle it first becomes visible.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_RSV_LO = 3'b000,
    SRC_ZERO   = 3'b001,
    SRC_PRD    = 3'b010,
    SRC_RSV_HI = 3'b011,
    SRC_CA_UP  = 3'b100,
    SRC_CA_DN  = 3'b101,
    SRC_CB_UP  = 3'b110,
    SRC_CB_DN  = 3'b111
  } src_e;
endpackage

// File: rtl/pwm_evt_sel.sv
module pwm_evt_sel
  import pwm_evt_pkg::*;
(
  input  logic             zero_i,
  input  logic             period_i,
  input  logic             cmpa_i,
  input  logic             cmpb_i,
  input  logic             dir_up_i,
  input  logic [SEL_W-1:0] src_sel_i,
  output logic             hit_o
);
  always_comb begin
    unique case (src_e'(src_sel_i))
      SRC_ZERO:  hit_o = zero_i;
      SRC_PRD:   hit_o = period_i;
      SRC_CA_UP: hit_o = cmpa_i & dir_up_i;
      SRC_CA_DN: hit_o = cmpa_i & ~dir_up_i;
      SRC_CB_UP: hit_o = cmpb_i & dir_up_i;
      SRC_CB_DN: hit_o = cmpb_i & ~dir_up_i;
      default:   hit_o = 1'b0;  // reserved codes
    endcase
  end
endmodule

// File: rtl/pwm_evt_prescale.sv
module pwm_evt_prescale #(
  parameter int unsigned PRD_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             en_i,
  input  logic [PRD_W-1:0] div_i,
  input  logic             flag_i,
  output logic             fire_o,
  output logic [PRD_W-1:0] cnt_o
);
  localparam int unsigned EXT_W = PRD_W + 1;

  logic [PRD_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] cnt_inc;
  logic             active;

  assign active  = (div_i != '0);
  assign cnt_inc = EXT_W'(cnt_q) + EXT_W'(1);
  assign fire_o  = active & en_i & hit_i & ~flag_i & (cnt_inc >= EXT_W'(div_i));

  always_comb begin
    cnt_d = cnt_q;
    if (!active)                        cnt_d = '0;
    else if (fire_o)                    cnt_d = '0;
    else if (en_i && hit_i && cnt_q < div_i) cnt_d = cnt_inc[PRD_W-1:0];  // saturate at divider
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_evt_flag.sv
module pwm_evt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // firing wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (fire_i) flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pwm_evt_irq.sv
module pwm_evt_irq
  import pwm_evt_pkg::*;
#(
  parameter int unsigned PRD_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  input  logic             period_i,
  input  logic             cmpa_i,
  input  logic             cmpb_i,
  input  logic             dir_up_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic             en_i,
  input  logic [PRD_W-1:0] div_i,
  input  logic             clr_i,
  output logic             irq_o,
  output logic [PRD_W-1:0] evt_cnt_o
);
  logic hit;
  logic fire;
  logic flag;

  pwm_evt_sel u_sel (
    .zero_i   (zero_i),
    .period_i (period_i),
    .cmpa_i   (cmpa_i),
    .cmpb_i   (cmpb_i),
    .dir_up_i (dir_up_i),
    .src_sel_i(src_sel_i),
    .hit_o    (hit)
  );

  pwm_evt_prescale #(.PRD_W(PRD_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (hit),
    .en_i  (en_i),
    .div_i (div_i),
    .flag_i(flag),
    .fire_o(fire),
    .cnt_o (evt_cnt_o)
  );

  pwm_evt_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(fire),
    .clr_i (clr_i),
    .flag_o(flag)
  );

  assign irq_o = flag;
endmodule

// File: rtl/pwm_evt_irq_chk.sv
module pwm_evt_irq_chk #(
  parameter int unsigned PRD_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       src_sel_i,
  input logic             en_i,
  input logic [PRD_W-1:0] div_i,
  input logic             clr_i,
  input logic             hit,
  input logic             irq_o,
  input logic [PRD_W-1:0] evt_cnt_o
);
  localparam int unsigned EXT_W = PRD_W + 1;

  // R5
  rsv_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 3'b000 || src_sel_i == 3'b011) |=> !$rose(irq_o));

  // R6
  dis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && div_i != '0) |=> ($stable(evt_cnt_o) && !$rose(irq_o)));

  // R7
  div_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == '0) |=> (evt_cnt_o == '0));

  // R7
  fire_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((EXT_W'($past(evt_cnt_o)) + EXT_W'(1) >= EXT_W'($past(div_i))) && evt_cnt_o == '0));

  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);

  // R8
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !irq_o);

  // R10
  clr_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !irq_o && hit && en_i && div_i == PRD_W'(1)) |=> irq_o);
endmodule

bind pwm_evt_irq pwm_evt_irq_chk #(.PRD_W(PRD_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_sel_i(src_sel_i),
  .en_i     (en_i),
  .div_i    (div_i),
  .clr_i    (clr_i),
  .hit      (hit),
  .irq_o    (irq_o),
  .evt_cnt_o(evt_cnt_o)
);

// File: tb/pwm_evt_irq_bench.sv
module pwm_evt_irq_bench;
  localparam int PRD_W = 2;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             zero_i = 0, period_i = 0, cmpa_i = 0, cmpb_i = 0, dir_up_i = 0;
  logic [2:0]       src_sel_i = 0;
  logic             en_i = 0;
  logic [PRD_W-1:0] div_i = 0;
  logic             clr_i = 0;
  logic             irq_o;
  logic [PRD_W-1:0] evt_cnt_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit m_flag = 0;
  int m_cnt  = 0;

  always #5 clk = ~clk;

  pwm_evt_irq #(.PRD_W(PRD_W)) u_pwm_evt_irq (
    .clk_i(clk), .rst_ni(rst_ni), .zero_i(zero_i), .period_i(period_i),
    .cmpa_i(cmpa_i), .cmpb_i(cmpb_i), .dir_up_i(dir_up_i), .src_sel_i(src_sel_i),
    .en_i(en_i), .div_i(div_i), .clr_i(clr_i), .irq_o(irq_o), .evt_cnt_o(evt_cnt_o)
  );

  function automatic bit sel_hit(bit z, bit p, bit a, bit b, bit up, int sel);
    case (sel)
      1: return z;
      2: return p;
      4: return a && up;
      5: return a && !up;
      6: return b && up;
      7: return b && !up;
      default: return 0;
    endcase
  endfunction

  function automatic void model_step();
    bit h;
    bit f;
    int d;
    d = int'(div_i);
    h = en_i && sel_hit(zero_i, period_i, cmpa_i, cmpb_i, dir_up_i, int'(src_sel_i));
    f = (d != 0) && h && !m_flag && (m_cnt + 1 >= d);
    if (d == 0) m_cnt = 0;
    else if (f) m_cnt = 0;
    else if (h && m_cnt < d) m_cnt = m_cnt + 1;
    m_flag = f || (m_flag && !clr_i);
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit z, bit p, bit a, bit b, bit up, int sel, bit en, int dv, bit clr, string tag);
    @(negedge clk);
    zero_i = z; period_i = p; cmpa_i = a; cmpb_i = b; dir_up_i = up;
    src_sel_i = 3'(sel); en_i = en; div_i = PRD_W'(dv); clr_i = clr;
    model_step();
    @(posedge clk);
    #2;
    check(tag, int'(irq_o), int'(m_flag), "irq");
    check(tag, int'(evt_cnt_o), m_cnt, "count");
  endtask

  task automatic quiet(int sel, int dv, string tag);
    step(0, 0, 0, 0, 1, sel, 1, dv, 1, tag);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(1234);
    repeat (2) @(negedge clk);
    #2;
    check("R1", int'(irq_o), 0, "irq in reset");
    check("R1", int'(evt_cnt_o), 0, "count in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", int'(irq_o), 0, "irq after reset");

    // R2: zero and period sources, divider 1
    step(1, 0, 0, 0, 1, 1, 1, 1, 0, "R2");
    check("R2", int'(irq_o), 1, "zero fires");
    quiet(1, 1, "R8");
    check("R8", int'(irq_o), 0, "cleared");
    step(1, 0, 0, 0, 1, 2, 1, 1, 0, "R2");
    check("R2", int'(irq_o), 0, "zero ignored on period code");
    step(0, 1, 0, 0, 1, 2, 1, 1, 0, "R2");
    check("R2", int'(irq_o), 1, "period fires");
    quiet(2, 1, "R8");

    // R3 / R4: direction qualified compares, divider 3 to watch the count
    step(0, 0, 1, 0, 0, 4, 1, 3, 0, "R3");
    check("R3", int'(evt_cnt_o), 0, "cmpA down ignored on up code");
    step(0, 0, 1, 0, 1, 4, 1, 3, 0, "R3");
    check("R3", int'(evt_cnt_o), 1, "cmpA up counted");
    step(0, 0, 1, 0, 0, 5, 1, 3, 0, "R3");
    check("R3", int'(evt_cnt_o), 2, "cmpA down counted");
    step(0, 0, 0, 1, 1, 7, 1, 3, 0, "R4");
    check("R4", int'(evt_cnt_o), 2, "cmpB up ignored on down code");
    step(0, 0, 0, 1, 0, 7, 1, 3, 0, "R4");
    check("R7", int'(irq_o), 1, "third event fires");
    check("R7", int'(evt_cnt_o), 0, "count restarts");
    quiet(6, 3, "R8");
    step(0, 0, 0, 1, 1, 6, 1, 3, 0, "R4");
    check("R4", int'(evt_cnt_o), 1, "cmpB up counted");

    // R5: reserved codes
    step(1, 1, 1, 1, 1, 0, 1, 3, 0, "R5");
    step(1, 1, 1, 1, 0, 3, 1, 3, 0, "R5");
    check("R5", int'(evt_cnt_o), 1, "reserved codes hold count");

    // R6: disabled
    step(1, 0, 0, 0, 1, 1, 0, 2, 0, "R6");
    step(1, 0, 0, 0, 1, 1, 0, 2, 0, "R6");
    check("R6", int'(irq_o), 0, "no irq while disabled");
    check("R6", int'(evt_cnt_o), 1, "count holds while disabled");

    // R7: divider 2 and divider off
    step(1, 0, 0, 0, 1, 1, 1, 2, 0, "R7");
    check("R7", int'(irq_o), 1, "second event fires");
    step(1, 0, 0, 0, 1, 1, 1, 0, 1, "R7");
    check("R7", int'(evt_cnt_o), 0, "divider off");

    // R9: saturation while flag high, immediate fire after clear
    step(1, 0, 0, 0, 1, 1, 1, 2, 0, "R9");
    step(1, 0, 0, 0, 1, 1, 1, 2, 0, "R9");
    step(1, 0, 0, 0, 1, 1, 1, 2, 0, "R9");
    step(1, 0, 0, 0, 1, 1, 1, 2, 0, "R9");
    check("R9", int'(evt_cnt_o), 2, "saturates at divider");
    step(0, 0, 0, 0, 1, 1, 1, 2, 1, "R9");
    check("R9", int'(irq_o), 0, "cleared");
    step(1, 0, 0, 0, 1, 1, 1, 2, 0, "R9");
    check("R9", int'(irq_o), 1, "fires on first event after clear");

    // R10: clear and firing together
    step(0, 0, 0, 0, 1, 1, 1, 1, 1, "R10");
    step(1, 0, 0, 0, 1, 1, 1, 1, 1, "R10");
    check("R10", int'(irq_o), 1, "fire beats clear");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int sel_r;
      int dv_r;
      sel_r = (i % 64 == 0) ? int'($urandom_range(0, 7)) : int'(src_sel_i);
      dv_r  = (i % 97 == 0) ? int'($urandom_range(0, 3)) : int'(div_i);
      step(($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
           1'($urandom_range(0, 1)), sel_r, ($urandom_range(0, 9) != 0),
           dv_r, ($urandom_range(0, 5) == 0), "R7 random model");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule